// File: doc/BRIEF.md
# Audio Subframe Builder with Channel Remap

This block turns the 32-bit audio words read from a sample FIFO into 28-bit subframes for the sample subpackets of an HDMI audio stream. It keeps the low 24 bits of each word as audio payload and appends four status bits: validity, user, channel status and parity. It also tags subframes that open a 192-frame channel-status block, and it gives each sample an output channel slot.

A frame holds one sample per active channel, sent in ascending channel index order. Layout 0 carries two interleaved channels. Layout 1 carries 2, 4, 6 or 8. In layout 1 each channel's slot is its index plus a per-channel 3-bit offset, modulo 8. Only the first 40 channel-status bits are programmable; later frames of the block carry zero. Building the packet header is left to the next stage.

Top module: `iec_subframe_builder`

## Requirements
- R1: Output word bits [23:0] equal input word bits [23:0]; input bits [31:24] never reach the output.
- R2: The user bit (output word bit 25) is always 0.
- R3: The validity bit (output word bit 24) equals the `v_invalid` input for every subframe (0 marks a valid sample).
- R4: The channel-status bit (output word bit 26) of every subframe in frame f of the block is `cs_bits[f]` for f below 40 and 0 for f from 40 to 191.
- R5: The parity bit (output word bit 27) makes the count of ones over all 28 output bits even.
- R6: The frame index advances by one after the sample of the highest active channel is accepted, and wraps from 191 to 0.
- R7: `out_blk` is 1 on every subframe of frame 0 of a block and 0 on all other subframes.
- R8: While `aud_en` is 0 no subframe is produced and the frame index returns to 0, so the first frame after enable opens a block.
- R9: In layout 0 (`layout`=0) channels 0 and 1 are active and `out_slot` equals the input channel index; offsets have no effect.
- R10: In layout 1 the active count is 2*(`ch_code`+1) and `out_slot` equals (channel + `ch_ofs[3*ch+2:3*ch]`) modulo 8.
- R11: A sample whose channel index is not below the active count produces no subframe and does not advance the frame index.
- R12: Each accepted sample appears on the outputs one clock after it is presented; after reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aud_en | input | 1 | Audio enable; low holds the block at frame 0 |
| layout | input | 1 | 0: stereo, 1: multichannel |
| ch_code | input | 2 | Multichannel count code, count = 2*(code+1) |
| cs_bits | input | 40 | Programmable channel-status bits, bit f used in frame f |
| v_invalid | input | 1 | Validity bit value applied to all subframes |
| ch_ofs | input | 24 | Per-channel 3-bit slot offsets, channel k at bits 3k+2..3k |
| in_valid | input | 1 | Input sample present |
| in_chan | input | 3 | Input channel index |
| in_data | input | 32 | Input word, audio in bits 23..0 |
| out_valid | output | 1 | Subframe present |
| out_word | output | 28 | Subframe: parity, status, user, validity, audio |
| out_slot | output | 3 | Output channel slot |
| out_blk | output | 1 | Subframe belongs to the first frame of a block |

## Verification
On every cycle the assertions hold the even parity of each emitted word, the silence and frame-index clear while disabled, the drop of out-of-range channels, the wrap of the frame index at the block end and its bound. The exact channel-status bit per frame, the slot arithmetic under offsets, the passing of audio bits and the block flag after a wrap or a re-enable are value questions that only the bench's sweeps over whole blocks in both layouts can show.

// File: rtl/iec_subframe_builder.sv
module iec_subframe_builder #(
  parameter int BLOCK_LEN = 192,
  parameter int CS_LEN    = 40,
  parameter int MAXCH     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     aud_en,
  input  logic                     layout,
  input  logic [$clog2(MAXCH)-2:0] ch_code,
  input  logic [CS_LEN-1:0]        cs_bits,
  input  logic                     v_invalid,
  input  logic [MAXCH*$clog2(MAXCH)-1:0] ch_ofs,
  input  logic                     in_valid,
  input  logic [$clog2(MAXCH)-1:0] in_chan,
  input  logic [31:0]              in_data,
  output logic                     out_valid,
  output logic [27:0]              out_word,
  output logic [$clog2(MAXCH)-1:0] out_slot,
  output logic                     out_blk
);
  localparam int CW = $clog2(MAXCH);
  localparam int FW = $clog2(BLOCK_LEN);

  logic [FW-1:0] fcnt;
  logic [CW:0]   active;
  logic          in_range, take, last, cbit, par;
  logic [CW-1:0] ofs, slot;
  logic [26:0]   body;
  logic [BLOCK_LEN-1:0] cs_full;

  assign active   = layout ? ({1'b0, ch_code, 1'b0} + (CW+1)'(2)) : (CW+1)'(2);
  assign in_range = {1'b0, in_chan} < active;
  assign take     = aud_en & in_valid & in_range;
  assign last     = {1'b0, in_chan} == active - (CW+1)'(1);
  assign ofs      = ch_ofs[in_chan*CW +: CW];
  assign slot     = layout ? in_chan + ofs : in_chan;
  assign cs_full  = {{(BLOCK_LEN-CS_LEN){1'b0}}, cs_bits};
  assign cbit     = cs_full[fcnt];
  assign body     = {cbit, 1'b0, v_invalid, in_data[23:0]};
  assign par      = ^body;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fcnt <= '0;
    else if (!aud_en) fcnt <= '0;
    else if (take && last)
      fcnt <= (fcnt == FW'(BLOCK_LEN-1)) ? '0 : fcnt + FW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_slot  <= '0;
      out_blk   <= 1'b0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_word <= {par, body};
        out_slot <= slot;
        out_blk  <= (fcnt == '0);
      end
    end
  end

  p_parity_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_word) % 2 == 0));
  p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !aud_en |=> (!out_valid && fcnt == '0));
  p_drop_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_range) |=> (!out_valid && $stable(fcnt)));
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (aud_en && take && last && fcnt == FW'(BLOCK_LEN-1)) |=> (fcnt == '0));
  p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt < FW'(BLOCK_LEN));
endmodule

// File: tb/iec_subframe_builder_tb.sv
module iec_subframe_builder_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic aud_en = 0, layout = 0, v_invalid = 0, in_valid = 0;
  logic [1:0]  ch_code = 0;
  logic [39:0] cs_bits = 40'hC35AA50F71;
  logic [23:0] ch_ofs = 0;
  logic [2:0]  in_chan = 0;
  logic [31:0] in_data = 0;
  logic        out_valid, out_blk;
  logic [27:0] out_word;
  logic [2:0]  out_slot;

  int errors = 0, checks = 0, ef = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iec_subframe_builder u_dut (
    .clk(clk), .rst_n(rst_n), .aud_en(aud_en), .layout(layout), .ch_code(ch_code),
    .cs_bits(cs_bits), .v_invalid(v_invalid), .ch_ofs(ch_ofs), .in_valid(in_valid),
    .in_chan(in_chan), .in_data(in_data), .out_valid(out_valid), .out_word(out_word),
    .out_slot(out_slot), .out_blk(out_blk));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s frame=%0d actual=%h expected=%h", tag, ef, act, exp);
    end
  endtask

  task automatic send(input int ch, input logic [31:0] d);
    int act;
    bit tk;
    logic [2:0] es;
    logic ec;
    logic [26:0] eb;
    act = layout ? 2*(int'(ch_code)+1) : 2;
    tk = aud_en && ch < act;
    es = layout ? 3'((ch + int'(ch_ofs[ch*3 +: 3])) % 8) : 3'(ch);
    ec = (ef < 40) ? cs_bits[ef] : 1'b0;
    eb = {ec, 1'b0, v_invalid, d[23:0]};
    @(negedge clk);
    in_valid = 1; in_chan = 3'(ch); in_data = d;
    @(posedge clk); #1;
    in_valid = 0;
    if (!tk) chk(out_valid == 0, "R11 dropped sample", 32'(out_valid), 0);
    else begin
      chk(out_valid == 1, "R12 latency", 32'(out_valid), 1);
      chk(out_word[23:0] == d[23:0], "R1 audio", 32'(out_word[23:0]), 32'(d[23:0]));
      chk(out_word[25] == 0, "R2 user", 32'(out_word[25]), 0);
      chk(out_word[24] == v_invalid, "R3 validity", 32'(out_word[24]), 32'(v_invalid));
      chk(out_word[26] == ec, "R4 channel status", 32'(out_word[26]), 32'(ec));
      chk(out_word[27] == ^eb, "R5 parity", 32'(out_word[27]), 32'(^eb));
      chk(out_blk == (ef == 0), "R7 R6 block start", 32'(out_blk), 32'(ef == 0));
      chk(out_slot == es, layout ? "R10 slot" : "R9 slot", 32'(out_slot), 32'(es));
      if (ch == act-1) ef = (ef == 191) ? 0 : ef + 1;
    end
  endtask

  task automatic frames(input int n, input int extra_ch);
    int act;
    act = layout ? 2*(int'(ch_code)+1) : 2;
    for (int f = 0; f < n; f++) begin
      for (int c = 0; c < act; c++)
        send(c, {8'(f ^ 8'hA5), 8'(c * 29), 16'(f * 977 + c)});
      if (extra_ch >= 0 && f % 7 == 3) send(extra_ch, 32'hDEADBEEF);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    chk(out_valid == 0, "R12 reset", 32'(out_valid), 0);
    @(negedge clk); rst_n = 1;
    // stereo, offsets set but ignored, two blocks plus a few frames
    ch_ofs = 24'o76543217;
    @(negedge clk); aud_en = 1; ef = 0;
    frames(389, 2);
    // disable mid-block, then re-enable at frame 0
    @(negedge clk); aud_en = 0; ef = 0;
    send(0, 32'h11223344);
    @(negedge clk); aud_en = 1;
    frames(45, -1);
    // multichannel, 8 channels, remap, invalid samples
    @(negedge clk); aud_en = 0; ef = 0;
    layout = 1; ch_code = 3; v_invalid = 1;
    for (int k = 0; k < 8; k++) ch_ofs[k*3 +: 3] = 3'((k*3 + 1) % 8);
    cs_bits = 40'h5F0E1D2C3B;
    @(negedge clk); aud_en = 1;
    frames(200, -1);
    // four channels with out-of-range indices
    @(negedge clk); aud_en = 0; ef = 0;
    ch_code = 1; v_invalid = 0;
    @(negedge clk); aud_en = 1;
    frames(50, 5);
    frames(3, 7);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule